// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block forms the control-store address of the next microinstruction in a microprogrammed control unit and holds it in the microprogram counter. It takes the fields of the current microinstruction (a 9-bit successor address, two flag-jam controls and an opcode-dispatch control), the ALU negative and zero flags, and an opcode byte fetched from the instruction stream. The successor address is never added to or selected against another target. Conditional branches set the address high bit from flag terms. Opcode dispatch merges the opcode byte into the low address bits with a bitwise OR.

The ALU flags are held in registers for one cycle, so a jam always tests the flags left by the previous microinstruction. The block also turns the encoded source-select field of the operand bus into one-hot drive enables, so that exactly one register drives that bus. The destination bitmap of the result bus passes straight through as per-register load enables.

Top module: `uctl_sequencer`

## Requirements
- R1: While rst_ni is low, mpc_o is 0 and both flag registers are cleared. The first microinstruction after reset therefore sees N=0 and Z=0.
- R2: On each rising clock edge mpc_o loads the newly formed address. With jamn_i, jamz_i and jmpc_i all low, that address equals next_addr_i.
- R3: Bit 8 (the top bit) of the new address is (jamz_i AND Z) OR (jamn_i AND N) OR next_addr_i[8].
- R4: When jmpc_i is high, bits 7..0 of the new address are next_addr_i[7:0] bitwise OR mbr_i. When jmpc_i is low, they are next_addr_i[7:0].
- R5: jmpc_i never changes bit 8 of the new address. That bit is still produced by R3.
- R6: With next_addr_i = 0x1FF and jmpc_i high, the new address is 0x1FF for every mbr_i value.
- R7: N and Z are the values alu_n_i and alu_z_i had at the previous rising edge. A change on those inputs between edges does not affect the address formed in the current cycle.
- R8: b_en_o has bit k set, and no other bit set, when b_sel_i equals k and k < 9. For b_sel_i values 9 to 15 it is all zeros. The output is combinational.
- R9: c_load_o equals c_map_i combinationally, so any number of bits may be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| next_addr_i | input | 9 | Successor address field of the current microinstruction |
| jamn_i | input | 1 | Jam the high bit with the N flag |
| jamz_i | input | 1 | Jam the high bit with the Z flag |
| jmpc_i | input | 1 | OR the opcode byte into the low address bits |
| mbr_i | input | 8 | Opcode byte |
| alu_n_i | input | 1 | ALU negative result, registered at the edge |
| alu_z_i | input | 1 | ALU zero result, registered at the edge |
| b_sel_i | input | 4 | Encoded operand-bus source select |
| c_map_i | input | 9 | Result-bus destination bitmap |
| mpc_o | output | 9 | Microprogram counter |
| b_en_o | output | 9 | One-hot operand-bus drive enables |
| c_load_o | output | 9 | Per-register load enables |

## Verification
The bench builds the block with its default parameters: a 9-bit address, an 8-bit opcode byte, a 4-bit source select with nine assigned sources, and nine result registers. At this size all sixteen combinations of the two jam controls and the two flags can be applied. So can every source-select code, including the seven unassigned ones, and the all-ones successor address that absorbs any dispatch byte. Flag inputs are toggled between the capturing edge and the using edge, which shows whether the jam reads the registered flags or the live ALU outputs.

// File: rtl/uctl_pkg.sv
package uctl_pkg;
  typedef struct packed {
    logic jamn;
    logic jamz;
    logic jmpc;
  } jam_ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/uctl_flag_reg.sv
module uctl_flag_reg
  import uctl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t alu_i,
  output flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= alu_i;
  end
endmodule

// File: rtl/uctl_addr_form.sv
module uctl_addr_form
  import uctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DISP_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] next_addr_i,
  input  jam_ctrl_t         ctrl_i,
  input  flags_t            flags_i,
  input  logic [DISP_W-1:0] mbr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic              hi_bit;
  logic [DISP_W-1:0] lo_bits;

  // jam terms only ever set the top bit
  always_comb begin
    hi_bit = (ctrl_i.jamz & flags_i.z) | (ctrl_i.jamn & flags_i.n)
           | next_addr_i[ADDR_W-1];
  end

  // dispatch merges the opcode into the low bits, no adder
  always_comb begin
    lo_bits = next_addr_i[DISP_W-1:0];
    if (ctrl_i.jmpc) lo_bits = lo_bits | mbr_i;
  end

  assign addr_o = {hi_bit, lo_bits};
endmodule

// File: rtl/uctl_bsel_dec.sv
module uctl_bsel_dec #(
  parameter int unsigned BSEL_W = 4,
  parameter int unsigned N_BSRC = 9
) (
  input  logic [BSEL_W-1:0] sel_i,
  output logic [N_BSRC-1:0] en_o
);
  for (genvar k = 0; k < N_BSRC; k++) begin : g_src
    assign en_o[k] = (sel_i == BSEL_W'(k));
  end
endmodule

// File: rtl/uctl_sequencer.sv
module uctl_sequencer
  import uctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DISP_W = ADDR_W - 1,
  parameter int unsigned BSEL_W = 4,
  parameter int unsigned N_BSRC = 9,
  parameter int unsigned N_CREG = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              jamn_i,
  input  logic              jamz_i,
  input  logic              jmpc_i,
  input  logic [DISP_W-1:0] mbr_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  input  logic [BSEL_W-1:0] b_sel_i,
  input  logic [N_CREG-1:0] c_map_i,
  output logic [ADDR_W-1:0] mpc_o,
  output logic [N_BSRC-1:0] b_en_o,
  output logic [N_CREG-1:0] c_load_o
);
  localparam int unsigned SEL_CODES = 1 << BSEL_W;

  if (N_BSRC > SEL_CODES) begin : g_bad_cfg
    initial $error("N_BSRC exceeds select codes");
  end

  flags_t            alu_flags, flags_q;
  jam_ctrl_t         ctrl;
  logic [ADDR_W-1:0] addr_d;

  assign alu_flags = '{n: alu_n_i, z: alu_z_i};
  assign ctrl      = '{jamn: jamn_i, jamz: jamz_i, jmpc: jmpc_i};

  uctl_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alu_i  (alu_flags),
    .flags_o(flags_q)
  );

  uctl_addr_form #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_form (
    .next_addr_i(next_addr_i),
    .ctrl_i     (ctrl),
    .flags_i    (flags_q),
    .mbr_i      (mbr_i),
    .addr_o     (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mpc_o <= '0;
    else         mpc_o <= addr_d;
  end

  uctl_bsel_dec #(.BSEL_W(BSEL_W), .N_BSRC(N_BSRC)) u_bdec (
    .sel_i(b_sel_i),
    .en_o (b_en_o)
  );

  assign c_load_o = c_map_i;
endmodule

// File: rtl/uctl_sequencer_chk.sv
module uctl_sequencer_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DISP_W = ADDR_W - 1,
  parameter int unsigned BSEL_W = 4,
  parameter int unsigned N_BSRC = 9,
  parameter int unsigned N_CREG = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] next_addr_i,
  input logic              jamn_i,
  input logic              jamz_i,
  input logic              jmpc_i,
  input logic [DISP_W-1:0] mbr_i,
  input logic              alu_n_i,
  input logic              alu_z_i,
  input logic [BSEL_W-1:0] b_sel_i,
  input logic [N_CREG-1:0] c_map_i,
  input logic [ADDR_W-1:0] mpc_o,
  input logic [N_BSRC-1:0] b_en_o,
  input logic [N_CREG-1:0] c_load_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset_mpc: assert (mpc_o == '0);
  end

  a_r2_plain_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !jamn_i && !jamz_i && !jmpc_i) |=> mpc_o == $past(next_addr_i));

  a_r3_r7_hibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |=> mpc_o[ADDR_W-1] ==
      (($past(jamz_i) & $past(alu_z_i, 2)) | ($past(jamn_i) & $past(alu_n_i, 2))
       | $past(next_addr_i[ADDR_W-1])));

  a_r4_dispatch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && jmpc_i) |=> mpc_o[DISP_W-1:0] == $past(next_addr_i[DISP_W-1:0] | mbr_i));

  a_r6_top_absorbs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && jmpc_i && &next_addr_i) |=> &mpc_o);

  always_comb begin
    a_r8_onehot: assert ($onehot0(b_en_o));
    if (32'(b_sel_i) >= N_BSRC) a_r8_unassigned_idle: assert (b_en_o == '0);
    a_r9_cmap_pass: assert (c_load_o == c_map_i);
  end
endmodule

bind uctl_sequencer uctl_sequencer_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .BSEL_W(BSEL_W), .N_BSRC(N_BSRC), .N_CREG(N_CREG)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .next_addr_i(next_addr_i), .jamn_i(jamn_i),
  .jamz_i(jamz_i), .jmpc_i(jmpc_i), .mbr_i(mbr_i), .alu_n_i(alu_n_i),
  .alu_z_i(alu_z_i), .b_sel_i(b_sel_i), .c_map_i(c_map_i), .mpc_o(mpc_o),
  .b_en_o(b_en_o), .c_load_o(c_load_o)
);

// File: tb/uctl_sequencer_test.sv
module uctl_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] next_addr_i = '0;
  logic       jamn_i = 1'b0, jamz_i = 1'b0, jmpc_i = 1'b0;
  logic [7:0] mbr_i = '0;
  logic       alu_n_i = 1'b0, alu_z_i = 1'b0;
  logic [3:0] b_sel_i = '0;
  logic [8:0] c_map_i = '0;
  logic [8:0] mpc_o, b_en_o, c_load_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uctl_sequencer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .next_addr_i(next_addr_i), .jamn_i(jamn_i),
    .jamz_i(jamz_i), .jmpc_i(jmpc_i), .mbr_i(mbr_i), .alu_n_i(alu_n_i),
    .alu_z_i(alu_z_i), .b_sel_i(b_sel_i), .c_map_i(c_map_i), .mpc_o(mpc_o),
    .b_en_o(b_en_o), .c_load_o(c_load_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // latch flags at edge A, flip ALU inputs, form address at edge B
  task automatic step(logic n, logic z, logic [8:0] nxt, logic jn, logic jz,
                      logic jc, logic [7:0] mbr, string req);
    logic [8:0] exp;
    @(negedge clk_i);
    alu_n_i = n; alu_z_i = z;
    next_addr_i = nxt; jamn_i = jn; jamz_i = jz; jmpc_i = jc; mbr_i = mbr;
    @(negedge clk_i);
    alu_n_i = ~n; alu_z_i = ~z;
    @(negedge clk_i);
    exp[8]   = (jz & z) | (jn & n) | nxt[8];
    exp[7:0] = jc ? (nxt[7:0] | mbr) : nxt[7:0];
    check(req, 32'(mpc_o), 32'(exp));
  endtask

  task automatic t_reset();
    // R1: mpc cleared; first edge uses cleared flags
    rst_ni = 1'b0;
    #(CLK_PERIOD*2);
    check("R1 mpc", 32'(mpc_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    alu_n_i = 1'b1; alu_z_i = 1'b1;
    jamn_i = 1'b1; jamz_i = 1'b1; next_addr_i = 9'h005;
    @(negedge clk_i);
    check("R1 flags clear", 32'(mpc_o), 32'h005);
  endtask

  task automatic t_plain();
    step(1, 1, 9'h000, 0, 0, 0, 8'hFF, "R2");
    step(0, 0, 9'h1A5, 0, 0, 0, 8'h3C, "R2");
    step(1, 0, 9'h0FE, 0, 0, 0, 8'h00, "R2");
  endtask

  task automatic t_jam();
    // R3, R7: every combination of jam controls and flags
    for (int v = 0; v < 16; v++) begin
      step(v[0], v[1], 9'h042, v[2], v[3], 0, 8'h00, "R3/R7 jam");
      step(v[0], v[1], 9'h142, v[2], v[3], 0, 8'h00, "R3 hibit set");
    end
  endtask

  task automatic t_dispatch();
    for (int i = 0; i < 12; i++) begin
      logic [7:0] m;
      m = 8'($urandom);
      step(1'(i), 1'(i >> 1), 9'(i * 37), 1'(i >> 2), 1'b0, 1'b1, m, "R4 dispatch");
    end
    // R5: jmpc leaves the high bit to the jam logic
    step(0, 1, 9'h000, 0, 1, 1, 8'hFF, "R5 hi from jam");
    step(1, 1, 9'h000, 0, 0, 1, 8'hFF, "R5 no jam");
  endtask

  task automatic t_top();
    for (int i = 0; i < 6; i++)
      step(1'(i), 1'(i), 9'h1FF, 1'(i >> 1), 1'(i >> 2), 1, 8'($urandom), "R6 top");
  endtask

  task automatic t_bdec();
    for (int s = 0; s < 16; s++) begin
      @(negedge clk_i);
      b_sel_i = 4'(s);
      #1;
      check("R8 bdec", 32'(b_en_o), (s < 9) ? (32'd1 << s) : 32'd0);
    end
  endtask

  task automatic t_cmap();
    logic [8:0] pats [4] = '{9'h000, 9'h1FF, 9'h0A5, 9'h112};
    for (int i = 0; i < 4; i++) begin
      c_map_i = pats[i];
      #1;
      check("R9 cmap", 32'(c_load_o), 32'(pats[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_jam();
    t_dispatch();
    t_top();
    t_bdec();
    t_cmap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule